// File: doc/BRIEF.md
# Wired-Interrupt to Write-Message Bridge

This block gathers a bank of wired interrupt lines from a peripheral subsystem and turns each change on them into a single-beat memory-write message aimed at an upstream interrupt controller. Every line has its own configuration word. The word holds an enable bit, a trigger style, a group number and a payload. Two groups are supported. The first group, "NSR", has both a SET and a CLEAR target address. The second group, "SEI", has only a SET target. All target addresses are 64 bits wide and are shared by every line in the group.

Software programs the target addresses and the per-line words over a plain 32-bit register port. The writes leave on a valid/ready stream. A message stays on the output until the sink takes it. A sink that holds `msg_ready` low stalls the bridge. While stalled, the bridge keeps at most one unsent event per line and per kind, and a newer opposite event replaces an older one. When more than one line has a message waiting, a round-robin arbiter decides which line goes next.

Top module: `wirq_msg_bridge`

## Requirements
- R1: After reset, `msg_valid` is low and every target-address register and every configuration word reads back as zero.
- R2: The register map is as follows. The NSR SET address is at 0x10 (low half) and 0x14 (high half). The NSR CLEAR address is at 0x18 (low) and 0x1C (high). The SEI SET address is at 0x50 (low) and 0x54 (high). The configuration word of line x is at 0x100+4*x, for x from 0 to 206. A write to an offset past line 206 has no effect, and a read there returns zero.
- R3: A configuration word is laid out as follows: bits 31:29 are the group, bit 28 selects edge (1) or level (0), bit 24 is the enable, and bits 23:0 are the payload. A rising edge on an enabled line whose group is 0 (NSR) sends one message. Its address is the NSR SET address, and its data is the payload with the upper 8 bits set to zero.
- R4: A falling edge on an enabled NSR line of level type sends one message to the NSR CLEAR address, carrying the same data. A falling edge on an NSR line of edge type sends nothing.
- R5: A rising edge on an enabled line whose group is 3 (SEI) sends one message to the SEI SET address. A falling edge on an SEI line never sends anything, whatever its trigger bit says.
- R6: A line whose enable bit is clear, or whose group is neither 0 nor 3, sends nothing. Writing zero to a line's word removes any event that line still has waiting.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged. A message counts as delivered only in a cycle where both `msg_valid` and `msg_ready` are high, and each event is delivered once.
- R8: Lines that have events waiting at the same time are served in rising index order. The search starts at the line just after the last one served and wraps from 206 back to 0.
- R9: Lines 107 and 109 may carry identical configuration words. Each of them still sends its own messages for its own edges.
- R10: For each line, the most recent event wins. A falling edge on a level NSR line replaces an unsent SET with a CLEAR, and a rising edge replaces an unsent CLEAR with a SET.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 207 | Wired interrupt lines, asynchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| msg_valid | output | 1 | A write message is being offered |
| msg_ready | input | 1 | The sink accepts the offered message |
| msg_addr | output | 64 | Target address of the message |
| msg_data | output | 32 | Message data: payload with the upper bits zero |

## Verification
The bench walks single lines through rise and fall under each combination of group, trigger type and enable. This tells apart the SET path, the CLEAR path and suppressed edges. Three lines are raised together while the sink stalls, which exposes the round-robin order and the hold rule at the output. A pulse that rises and falls while the output is blocked shows that the latest event replaces the earlier one. A word cleared while its event is still waiting shows that the event is removed. A seeded random pass over lines and words, checked against a bench model, catches any mix-up between the address and data of the groups.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int REG_AW      = 12;
  localparam int PAYLOAD_W   = 24;
  localparam int CFG_EN_BIT  = 24;
  localparam int CFG_TRIG_BIT = 28;
  localparam int CFG_GRP_LSB = 29;

  localparam logic [2:0] GRP_NSR = 3'd0;
  localparam logic [2:0] GRP_SEI = 3'd3;

  localparam logic [REG_AW-1:0] OFS_NSR_SET_LO = 12'h010;
  localparam logic [REG_AW-1:0] OFS_NSR_SET_HI = 12'h014;
  localparam logic [REG_AW-1:0] OFS_NSR_CLR_LO = 12'h018;
  localparam logic [REG_AW-1:0] OFS_NSR_CLR_HI = 12'h01C;
  localparam logic [REG_AW-1:0] OFS_SEI_SET_LO = 12'h050;
  localparam logic [REG_AW-1:0] OFS_SEI_SET_HI = 12'h054;
  localparam logic [REG_AW-1:0] OFS_CFG_BASE   = 12'h100;

  typedef enum logic {KIND_SET = 1'b0, KIND_CLR = 1'b1} msg_kind_e;

  function automatic logic [2:0] cfg_group(input logic [31:0] w);
    return w[CFG_GRP_LSB +: 3];
  endfunction

  // A word can produce messages at all.
  function automatic logic cfg_live(input logic [31:0] w);
    return w[CFG_EN_BIT] && (cfg_group(w) == GRP_NSR || cfg_group(w) == GRP_SEI);
  endfunction

  // Falling edges matter only for level-type lines of the NSR group.
  function automatic logic cfg_wants_clr(input logic [31:0] w);
    return cfg_live(w) && cfg_group(w) == GRP_NSR && !w[CFG_TRIG_BIT];
  endfunction
endpackage

// File: rtl/wmb_cfg_regs.sv
module wmb_cfg_regs
  import wmb_pkg::*;
#(
  parameter int NUM_LINES = 207
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic [NUM_LINES-1:0][31:0]  cfg_q,
  output logic [63:0]                 nsr_set_addr,
  output logic [63:0]                 nsr_clr_addr,
  output logic [63:0]                 sei_set_addr
);
  localparam int LW = REG_AW - 2;
  localparam logic [REG_AW:0] CFG_END = (REG_AW+1)'(int'(OFS_CFG_BASE) + 4*NUM_LINES);

  logic                  cfg_hit;
  logic [REG_AW-1:0]     cfg_off;
  logic [NUM_LINES-1:0]  line_sel;

  assign cfg_off = reg_addr - OFS_CFG_BASE;
  assign cfg_hit = (reg_addr >= OFS_CFG_BASE) && ({1'b0, reg_addr} < CFG_END) &&
                   (reg_addr[1:0] == 2'b00);

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      line_sel[i] = cfg_hit && (cfg_off[REG_AW-1:2] == LW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (line_sel[i]) cfg_q[i] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsr_set_addr <= '0;
      nsr_clr_addr <= '0;
      sei_set_addr <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_NSR_SET_LO: nsr_set_addr[31:0]  <= reg_wdata;
        OFS_NSR_SET_HI: nsr_set_addr[63:32] <= reg_wdata;
        OFS_NSR_CLR_LO: nsr_clr_addr[31:0]  <= reg_wdata;
        OFS_NSR_CLR_HI: nsr_clr_addr[63:32] <= reg_wdata;
        OFS_SEI_SET_LO: sei_set_addr[31:0]  <= reg_wdata;
        OFS_SEI_SET_HI: sei_set_addr[63:32] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_NSR_SET_LO: reg_rdata = nsr_set_addr[31:0];
      OFS_NSR_SET_HI: reg_rdata = nsr_set_addr[63:32];
      OFS_NSR_CLR_LO: reg_rdata = nsr_clr_addr[31:0];
      OFS_NSR_CLR_HI: reg_rdata = nsr_clr_addr[63:32];
      OFS_SEI_SET_LO: reg_rdata = sei_set_addr[31:0];
      OFS_SEI_SET_HI: reg_rdata = sei_set_addr[63:32];
      default: ;
    endcase
    for (int i = 0; i < NUM_LINES; i++) begin
      if (line_sel[i]) reg_rdata = cfg_q[i];
    end
  end
endmodule

// File: rtl/wmb_edge_detect.sv
module wmb_edge_detect #(
  parameter int NUM_LINES   = 207,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] rise,
  output logic [NUM_LINES-1:0] fall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_LINES-1:0] stage [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q;

  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[k] <= '0;
      else if (k == 0) stage[k] <= irq_in;
      else stage[k] <= stage[(k == 0) ? 0 : k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= stage[LAST];
  end

  assign rise = stage[LAST] & ~prev_q;
  assign fall = ~stage[LAST] & prev_q;
endmodule

// File: rtl/wmb_rr_arb.sv
module wmb_rr_arb #(
  parameter int NUM_LINES = 207,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req,
  input  logic                 take,
  output logic                 gnt_valid,
  output logic [IW-1:0]        gnt_idx
);
  logic [IW-1:0] ptr_q;
  logic [IW:0]   cand;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    cand      = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      cand = {1'b0, ptr_q} + (IW+1)'(k);
      if (cand >= (IW+1)'(NUM_LINES)) cand = cand - (IW+1)'(NUM_LINES);
      if (!gnt_valid && req[cand[IW-1:0]]) begin
        gnt_valid = 1'b1;
        gnt_idx   = cand[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (take) ptr_q <= (gnt_idx == IW'(NUM_LINES-1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/wirq_msg_bridge.sv
module wirq_msg_bridge
  import wmb_pkg::*;
#(
  parameter int NUM_LINES   = 207,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int IW = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0][31:0] cfg_q;
  logic [63:0]                nsr_set_addr, nsr_clr_addr, sei_set_addr;
  logic [NUM_LINES-1:0]       rise, fall, set_pend, clr_pend;
  logic                       gnt_valid, take, xfer;
  logic [IW-1:0]              gnt_idx, out_idx;
  msg_kind_e                  out_kind;
  logic [31:0]                sel_cfg;
  logic                       unused_rsvd;

  wmb_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_q(cfg_q),
    .nsr_set_addr(nsr_set_addr), .nsr_clr_addr(nsr_clr_addr),
    .sei_set_addr(sei_set_addr)
  );

  wmb_edge_detect #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise), .fall(fall)
  );

  wmb_rr_arb #(.NUM_LINES(NUM_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(set_pend | clr_pend), .take(take),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  assign take = !msg_valid && gnt_valid;
  assign xfer = msg_valid && msg_ready;

  always_comb begin
    unused_rsvd = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) unused_rsvd = unused_rsvd ^ (^cfg_q[i][27:25]);
  end

  // Per-line event flags: the newest event replaces an opposite unsent one.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic set_q, clr_q, live, want_clr, served;
    assign live     = cfg_live(cfg_q[i]);
    assign want_clr = cfg_wants_clr(cfg_q[i]);
    assign served   = xfer && (out_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        set_q <= 1'b0;
        clr_q <= 1'b0;
      end else if (!live) begin
        set_q <= 1'b0;
        clr_q <= 1'b0;
      end else if (rise[i]) begin
        set_q <= 1'b1;
        clr_q <= 1'b0;
      end else if (fall[i] && want_clr) begin
        set_q <= 1'b0;
        clr_q <= 1'b1;
      end else if (served) begin
        if (out_kind == KIND_SET) set_q <= 1'b0;
        else                      clr_q <= 1'b0;
      end
    end

    assign set_pend[i] = set_q;
    assign clr_pend[i] = clr_q;
  end

  assign sel_cfg = cfg_q[gnt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      out_idx   <= '0;
      out_kind  <= KIND_SET;
    end else if (take) begin
      msg_valid <= 1'b1;
      out_idx   <= gnt_idx;
      msg_data  <= 32'(sel_cfg[PAYLOAD_W-1:0]);
      if (set_pend[gnt_idx]) begin
        out_kind <= KIND_SET;
        msg_addr <= (cfg_group(sel_cfg) == GRP_SEI) ? sei_set_addr : nsr_set_addr;
      end else begin
        out_kind <= KIND_CLR;
        msg_addr <= nsr_clr_addr;
      end
    end else if (xfer) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wirq_msg_bridge_chk.sv
module wirq_msg_bridge_chk #(
  parameter int NUM_LINES = 207
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [63:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic [NUM_LINES-1:0] set_pend,
  input logic [NUM_LINES-1:0] clr_pend,
  input logic [63:0]          nsr_set_addr,
  input logic [63:0]          nsr_clr_addr,
  input logic [63:0]          sei_set_addr
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !msg_valid); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R7

  AST_ADDR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr == nsr_set_addr || msg_addr == nsr_clr_addr ||
                   msg_addr == sei_set_addr)); // R3

  AST_DATA_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[31:24] == 8'h00); // R3

  AST_PEND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pend & clr_pend) == '0); // R10
endmodule

bind wirq_msg_bridge wirq_msg_bridge_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .set_pend(set_pend),
  .clr_pend(clr_pend), .nsr_set_addr(nsr_set_addr),
  .nsr_clr_addr(nsr_clr_addr), .sei_set_addr(sei_set_addr)
);

// File: tb/wirq_msg_bridge_tb.sv
`timescale 1ns/1ps
module wirq_msg_bridge_tb;
  localparam int N = 207;
  localparam logic [63:0] A_NSR_SET = 64'h0000_00A1_F000_0040;
  localparam logic [63:0] A_NSR_CLR = 64'h0000_00A1_F000_0048;
  localparam logic [63:0] A_SEI_SET = 64'h0000_00B2_E000_0070;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         reg_we = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid;
  logic         msg_ready = 1'b1;
  logic [63:0]  msg_addr;
  logic [31:0]  msg_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [95:0] mq[$];

  always #10 clk = ~clk;

  wirq_msg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  always @(negedge clk) if (rst_n && msg_valid && msg_ready) mq.push_back({msg_addr, msg_data});

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit en, input bit edg,
                                         input logic [2:0] grp, input logic [23:0] pl);
    return {grp, edg, 3'b000, en, pl};
  endfunction

  // Bench model of R3..R6: does an edge produce a message, and where to.
  function automatic bit exp_msg(input logic [31:0] c, input bit rising,
                                 output logic [95:0] m);
    bit ok;
    logic [63:0] a;
    ok = 1'b0;
    a = '0;
    if (c[24] && (c[31:29] == 3'd0 || c[31:29] == 3'd3)) begin
      if (rising) begin
        ok = 1'b1;
        a = (c[31:29] == 3'd3) ? A_SEI_SET : A_NSR_SET;
      end else if (c[31:29] == 3'd0 && !c[28]) begin
        ok = 1'b1;
        a = A_NSR_CLR;
      end
    end
    m = {a, 8'h00, c[23:0]};
    return ok;
  endfunction

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic reg_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, "register readback", {64'h0, reg_rdata}, {64'h0, exp});
  endtask

  task automatic expect_msg(input logic [95:0] exp, input string req);
    int waited;
    logic [95:0] got;
    waited = 0;
    while (mq.size() == 0 && waited < 40) begin tick(1); waited++; end
    if (mq.size() == 0) begin
      check(1'b0, req, "message missing", '0, exp);
    end else begin
      got = mq.pop_front();
      check(got == exp, req, "message", got, exp);
    end
  endtask

  task automatic expect_quiet(input string req);
    tick(12);
    check(mq.size() == 0, req, "unexpected message",
          (mq.size() != 0) ? mq[0] : 96'h0, 96'h0);
    mq.delete();
  endtask

  task automatic line_cfg(input int i, input logic [31:0] c);
    reg_write(12'h100 + 12'(4*i), c);
  endtask

  initial begin
    #(20 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog (R1..R10): actual=still running expected=finished");
    if (!done) $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [95:0] m;
    logic [31:0] c;
    logic [63:0] held_a;
    logic [31:0] held_d;
    void'($urandom(32'd20240611));

    tick(3);
    check(msg_valid == 1'b0, "R1", "valid in reset", {95'h0, msg_valid}, 96'h0);
    reg_check(12'h010, 32'h0, "R1");
    reg_check(12'h100, 32'h0, "R1");
    rst_n = 1'b1;
    tick(2);
    check(msg_valid == 1'b0, "R1", "valid after reset", {95'h0, msg_valid}, 96'h0);

    reg_write(12'h010, A_NSR_SET[31:0]); reg_write(12'h014, A_NSR_SET[63:32]);
    reg_write(12'h018, A_NSR_CLR[31:0]); reg_write(12'h01C, A_NSR_CLR[63:32]);
    reg_write(12'h050, A_SEI_SET[31:0]); reg_write(12'h054, A_SEI_SET[63:32]);
    reg_check(12'h014, A_NSR_SET[63:32], "R2");
    reg_check(12'h018, A_NSR_CLR[31:0], "R2");
    reg_check(12'h054, A_SEI_SET[63:32], "R2");

    // R2: last line exists, the slot after it does not.
    line_cfg(206, 32'h1234_5678);
    reg_write(12'h100 + 12'(4*207), 32'hDEAD_BEEF);
    reg_check(12'h100 + 12'(4*207), 32'h0, "R2");
    reg_check(12'h100 + 12'(4*206), 32'h1234_5678, "R2");
    line_cfg(206, 32'h0);

    // R3 / R4: level NSR line sends SET then CLEAR.
    c = mk_cfg(1, 0, 3'd0, 24'hABCDEF);
    line_cfg(0, c);
    irq_in[0] = 1'b1; void'(exp_msg(c, 1, m)); expect_msg(m, "R3");
    irq_in[0] = 1'b0; void'(exp_msg(c, 0, m)); expect_msg(m, "R4");
    // R4: edge NSR line, falling edge is silent.
    c = mk_cfg(1, 1, 3'd0, 24'h000111);
    line_cfg(1, c);
    irq_in[1] = 1'b1; void'(exp_msg(c, 1, m)); expect_msg(m, "R4");
    irq_in[1] = 1'b0; expect_quiet("R4");
    // R5: SEI line with level trigger bit still never clears.
    c = mk_cfg(1, 0, 3'd3, 24'h5E1000);
    line_cfg(2, c);
    irq_in[2] = 1'b1; void'(exp_msg(c, 1, m)); expect_msg(m, "R5");
    irq_in[2] = 1'b0; expect_quiet("R5");
    // R6: disabled line and unknown group.
    line_cfg(4, mk_cfg(0, 0, 3'd0, 24'h000444));
    irq_in[4] = 1'b1; expect_quiet("R6");
    irq_in[4] = 1'b0; expect_quiet("R6");
    line_cfg(6, mk_cfg(1, 0, 3'd1, 24'h000666));
    irq_in[6] = 1'b1; expect_quiet("R6");
    irq_in[6] = 1'b0; expect_quiet("R6");

    // R6: clearing a word drops its waiting event.
    msg_ready = 1'b0;
    line_cfg(31, mk_cfg(1, 1, 3'd0, 24'h000031));
    line_cfg(30, mk_cfg(1, 1, 3'd0, 24'h000030));
    irq_in[31] = 1'b1; tick(8);
    irq_in[30] = 1'b1; tick(8);
    line_cfg(30, 32'h0);
    msg_ready = 1'b1;
    expect_msg({A_NSR_SET, 32'h0000_0031}, "R6");
    expect_quiet("R6");
    irq_in[30] = 1'b0; irq_in[31] = 1'b0; expect_quiet("R6");

    // R9: shared word on lines 107 and 109.
    c = mk_cfg(1, 0, 3'd0, 24'h00BEEF);
    line_cfg(107, c); line_cfg(109, c);
    irq_in[107] = 1'b1; expect_msg({A_NSR_SET, 32'h0000_BEEF}, "R9");
    irq_in[109] = 1'b1; expect_msg({A_NSR_SET, 32'h0000_BEEF}, "R9");
    irq_in[107] = 1'b0; expect_msg({A_NSR_CLR, 32'h0000_BEEF}, "R9");
    expect_quiet("R9");
    irq_in[109] = 1'b0; expect_msg({A_NSR_CLR, 32'h0000_BEEF}, "R9");

    // R8: serve line 5 so the search starts at 6, then raise 3, 10, 200 together.
    line_cfg(5, mk_cfg(1, 1, 3'd0, 24'h000005));
    irq_in[5] = 1'b1; expect_msg({A_NSR_SET, 32'h5}, "R8");
    irq_in[5] = 1'b0; expect_quiet("R8");
    line_cfg(3, mk_cfg(1, 1, 3'd0, 24'h000003));
    line_cfg(10, mk_cfg(1, 1, 3'd0, 24'h00000A));
    line_cfg(200, mk_cfg(1, 1, 3'd3, 24'h0000C8));
    msg_ready = 1'b0;
    irq_in[3] = 1'b1; irq_in[10] = 1'b1; irq_in[200] = 1'b1;
    tick(10);
    held_a = msg_addr; held_d = msg_data;
    check(msg_valid == 1'b1, "R7", "valid while stalled", {95'h0, msg_valid}, 96'h1);
    tick(6);
    check(msg_valid && msg_addr == held_a && msg_data == held_d, "R7", "held message",
          {msg_addr, msg_data}, {held_a, held_d});
    check(mq.size() == 0, "R7", "transfer without ready", 96'(mq.size()), 96'h0);
    msg_ready = 1'b1;
    expect_msg({A_NSR_SET, 32'h0000_000A}, "R8");
    expect_msg({A_SEI_SET, 32'h0000_00C8}, "R8");
    expect_msg({A_NSR_SET, 32'h0000_0003}, "R8");
    expect_quiet("R7");
    irq_in[3] = 1'b0; irq_in[10] = 1'b0; irq_in[200] = 1'b0;
    expect_quiet("R8");

    // R10: pulse on a blocked line, only the CLEAR survives.
    line_cfg(20, mk_cfg(1, 0, 3'd0, 24'h000020));
    line_cfg(21, mk_cfg(1, 0, 3'd0, 24'h000021));
    msg_ready = 1'b0;
    irq_in[20] = 1'b1; tick(8);
    irq_in[21] = 1'b1; tick(8);
    irq_in[21] = 1'b0; tick(8);
    msg_ready = 1'b1;
    expect_msg({A_NSR_SET, 32'h0000_0020}, "R10");
    expect_msg({A_NSR_CLR, 32'h0000_0021}, "R10");
    expect_quiet("R10");
    irq_in[20] = 1'b0; expect_msg({A_NSR_CLR, 32'h0000_0020}, "R10");

    // Seeded random words on random lines, checked against the model.
    for (int it = 0; it < 30; it++) begin
      int ln;
      logic [2:0] g;
      ln = int'($urandom_range(0, N-1));
      case ($urandom_range(0, 3))
        0, 1: g = 3'd0;
        2: g = 3'd3;
        default: g = 3'd1 + 3'($urandom_range(0, 1));
      endcase
      c = mk_cfg(($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)), g,
                 24'($urandom()));
      line_cfg(ln, c);
      irq_in[ln] = 1'b1;
      if (exp_msg(c, 1, m)) expect_msg(m, "R3"); else expect_quiet("R6");
      irq_in[ln] = 1'b0;
      if (exp_msg(c, 0, m)) expect_msg(m, "R4"); else expect_quiet("R5");
      line_cfg(ln, 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule